// File: doc/BRIEF.md
# Serial receiver wakeup and idle detector

This block sits next to a UART receiver and manages two related jobs: it keeps the receiver in a sleep state, in which incoming characters are not handed on as data, until a chosen wakeup event occurs, and it recognises idle-line characters. The data shifter, the baud generator and the parity checker are outside it. The receiver supplies a synchronized receive line, a strobe marking each bit sample, pulses marking the start-bit and stop-bit samples, and the assembled character.

Software requests sleep with a one-cycle pulse. Two independent mode inputs then shape the behaviour. One chooses the wakeup event: either a character whose most significant bit is 1 (an address mark) or an idle line. The other chooses where counting of idle 1s begins: right after the start bit, which lets a run of trailing 1s in the data plus the stop bit count toward idle, or only after the stop bit, which avoids that false idle at the cost of requiring well-spaced frames.

Top module: `rx_wake_idle_det`

## Requirements
- R1: After reset, asleep, wake_pulse, idle_det and rx_accept are all 0, and the idle count is enabled but no idle can fire until a 0 sample has been seen.
- R2: A sleep_req pulse makes asleep read 1 from the next cycle on; while asleep with wake_sel = 0, a completed character gives no rx_accept.
- R3: With wake_sel = 0 and asleep = 1, the cycle that reports an idle character also raises wake_pulse for one cycle and clears asleep in that same cycle.
- R4: With wake_sel = 1 and asleep = 1, a stop sample whose character has its most significant bit at 1 raises wake_pulse and rx_accept together one cycle later and clears asleep; a most significant bit of 0 leaves the receiver asleep with no rx_accept.
- R5: The bit examined for the address mark is rx_char[7] when ninth_mode = 0 and rx_char[8] when ninth_mode = 1 (with the default 8-bit data width).
- R6: idle_det pulses for one cycle, one cycle after the bit sample that brings the count of consecutive counted 1 samples to 10 (ninth_mode = 0) or 11 (ninth_mode = 1).
- R7: Any 0 sample clears the running count of 1s.
- R8: idle_det fires at most once per run of 1s; it can fire again only after at least one 0 sample.
- R9: With idle_from_stop = 0, counting starts right after the start bit, so data 1s and the stop bit count, and a character of all 1s followed by one idle bit produces idle_det.
- R10: With idle_from_stop = 1, the start-bit sample halts counting and counting resumes after the stop-bit sample, which itself is not counted.
- R11: While awake, every stop sample gives a one-cycle rx_accept in the following cycle.
- R12: With wake_sel = 1, an idle character is still reported on idle_det but does not wake the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit sample |
| rx_line | input | 1 | Synchronized receive line value at the sample |
| start_seen | input | 1 | Qualifies the current sample as the start bit |
| stop_seen | input | 1 | Qualifies the current sample as the stop bit; character complete |
| rx_char | input | DATA_W+1 | Received character, valid with stop_seen |
| ninth_mode | input | 1 | 1 selects characters one bit longer than DATA_W |
| wake_sel | input | 1 | 0 wakes on idle line, 1 wakes on address mark |
| idle_from_stop | input | 1 | 0 counts idle 1s after the start bit, 1 after the stop bit |
| sleep_req | input | 1 | One-cycle request to put the receiver to sleep |
| asleep | output | 1 | Receiver is sleeping |
| wake_pulse | output | 1 | One-cycle wakeup event |
| idle_det | output | 1 | One-cycle idle character detection |
| rx_accept | output | 1 | One-cycle pulse: the completed character is passed on as data |

## Verification
The bench targets the false idle that counting from the start bit must produce after an all-ones character; a design that filtered it, or that counted the stop bit when told to start after it, would differ by one idle bit in when idle_det appears. It probes the exact count boundary in both character lengths, where an off-by-one counter reports idle one bit early or late, and the repeat case, where a design without rearming would fire idle_det on every further 1. It also selects the address-mark bit under both lengths, where picking the wrong bit either wakes on an ordinary character or misses the real mark, and checks that an idle line wakes nothing in address-mark mode.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic {
        WAKE_IDLE = 1'b0,
        WAKE_ADDR = 1'b1
    } wake_mode_e;

    typedef enum logic {
        IDLE_FROM_START = 1'b0,
        IDLE_FROM_STOP  = 1'b1
    } idle_start_e;

    // Bit times in one full character: start + data + stop (+ ninth bit).
    function automatic int idle_len(input int data_w, input logic ninth);
        return ninth ? data_w + 3 : data_w + 2;
    endfunction

endpackage

// File: rtl/rxw_idle_track.sv
module rxw_idle_track
    import rxw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_line,
    input  logic start_seen,
    input  logic stop_seen,
    input  logic ninth_mode,
    input  logic idle_from_stop,
    output logic idle_hit,
    output logic idle_det
);
    localparam int CW = $clog2(DATA_W + 4);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          en;
        logic          zero_seen;
        logic          det;
    } trk_t;

    trk_t q, d;
    logic [CW-1:0] target;
    logic          from_stop;

    always_comb begin
        target    = CW'(idle_len(DATA_W, ninth_mode));
        from_stop = (idle_start_e'(idle_from_stop) == IDLE_FROM_STOP);
        d         = q;
        d.det     = 1'b0;
        idle_hit  = 1'b0;
        if (bit_tick) begin
            if (start_seen) begin
                d.cnt = '0;
                d.en  = !from_stop;
                if (!rx_line) d.zero_seen = 1'b1;
            end else if (stop_seen && from_stop) begin
                d.cnt = '0;
                d.en  = 1'b1;
                if (!rx_line) d.zero_seen = 1'b1;
            end else if (!rx_line) begin
                d.cnt       = '0;
                d.zero_seen = 1'b1;
            end else if (q.en && (q.cnt < target)) begin
                d.cnt = q.cnt + 1'b1;
                if ((d.cnt == target) && q.zero_seen) begin
                    idle_hit    = 1'b1;
                    d.zero_seen = 1'b0;
                end
            end
        end
        d.det = idle_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt       <= '0;
            q.en        <= 1'b1;
            q.zero_seen <= 1'b0;
            q.det       <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign idle_det = q.det;

endmodule

// File: rtl/rxw_wake_ctrl.sv
module rxw_wake_ctrl
    import rxw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_tick,
    input  logic            stop_seen,
    input  logic [DATA_W:0] rx_char,
    input  logic            ninth_mode,
    input  logic            wake_sel,
    input  logic            sleep_req,
    input  logic            idle_hit,
    output logic            asleep,
    output logic            wake_pulse,
    output logic            rx_accept
);
    typedef struct packed {
        logic asleep;
        logic wake;
        logic accept;
    } wk_t;

    wk_t  q, d;
    logic msb;
    logic stop_ev;
    logic addr_mode;
    logic addr_wake;
    logic line_wake;

    always_comb begin
        msb       = ninth_mode ? rx_char[DATA_W] : rx_char[DATA_W-1];
        stop_ev   = bit_tick && stop_seen;
        addr_mode = (wake_mode_e'(wake_sel) == WAKE_ADDR);
        addr_wake = q.asleep && addr_mode && stop_ev && msb;
        line_wake = q.asleep && !addr_mode && idle_hit;
        d         = q;
        d.wake    = addr_wake || line_wake;
        d.accept  = stop_ev && (!q.asleep || addr_wake);
        if (d.wake) begin
            d.asleep = 1'b0;
        end else if (sleep_req) begin
            d.asleep = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign asleep     = q.asleep;
    assign wake_pulse = q.wake;
    assign rx_accept  = q.accept;

endmodule

// File: rtl/rx_wake_idle_det.sv
module rx_wake_idle_det #(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_tick,
    input  logic            rx_line,
    input  logic            start_seen,
    input  logic            stop_seen,
    input  logic [DATA_W:0] rx_char,
    input  logic            ninth_mode,
    input  logic            wake_sel,
    input  logic            idle_from_stop,
    input  logic            sleep_req,
    output logic            asleep,
    output logic            wake_pulse,
    output logic            idle_det,
    output logic            rx_accept
);
    logic idle_hit;

    rxw_idle_track #(.DATA_W(DATA_W)) u_idle (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_tick       (bit_tick),
        .rx_line        (rx_line),
        .start_seen     (start_seen),
        .stop_seen      (stop_seen),
        .ninth_mode     (ninth_mode),
        .idle_from_stop (idle_from_stop),
        .idle_hit       (idle_hit),
        .idle_det       (idle_det)
    );

    rxw_wake_ctrl #(.DATA_W(DATA_W)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .stop_seen  (stop_seen),
        .rx_char    (rx_char),
        .ninth_mode (ninth_mode),
        .wake_sel   (wake_sel),
        .sleep_req  (sleep_req),
        .idle_hit   (idle_hit),
        .asleep     (asleep),
        .wake_pulse (wake_pulse),
        .rx_accept  (rx_accept)
    );

endmodule

// File: rtl/rx_wake_idle_det_chk.sv
module rx_wake_idle_det_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic stop_seen,
    input logic wake_sel,
    input logic sleep_req,
    input logic asleep,
    input logic wake_pulse,
    input logic idle_det,
    input logic rx_accept
);
    a_r2_sleep_enter: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sleep_req) && !wake_pulse) |-> asleep);

    a_r2_no_data_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_accept && $past(asleep)) |-> wake_pulse);

    a_r3_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (!asleep && $past(asleep)));

    a_r3_line_wake_src: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse && !$past(wake_sel)) |-> idle_det);

    a_r4_addr_wake_src: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse && $past(wake_sel)) |-> ($past(stop_seen && bit_tick) && rx_accept));

    a_r8_idle_single: assert property (@(posedge clk) disable iff (!rst_n)
        idle_det |=> !idle_det);

    a_r11_accept_src: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept |-> $past(stop_seen && bit_tick));

    a_r12_addr_no_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_det && $past(wake_sel) && !$past(stop_seen && bit_tick)) |-> !wake_pulse);
endmodule

bind rx_wake_idle_det rx_wake_idle_det_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .stop_seen  (stop_seen),
    .wake_sel   (wake_sel),
    .sleep_req  (sleep_req),
    .asleep     (asleep),
    .wake_pulse (wake_pulse),
    .idle_det   (idle_det),
    .rx_accept  (rx_accept)
);

// File: tb/sim_rx_wake_idle_det.sv
`timescale 1ns/1ps
module sim_rx_wake_idle_det;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0, rx_line = 1'b1, start_seen = 1'b0, stop_seen = 1'b0;
    logic [DATA_W:0] rx_char = '0;
    logic ninth_mode = 1'b0, wake_sel = 1'b0, idle_from_stop = 1'b0, sleep_req = 1'b0;
    logic asleep, wake_pulse, idle_det, rx_accept;

    int n_chk = 0, n_fail = 0;
    int c_idle = 0, c_wake = 0, c_acc = 0;
    logic s_asleep, s_wake, s_idle, s_acc;

    always #4 clk = ~clk;

    rx_wake_idle_det #(.DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line),
        .start_seen(start_seen), .stop_seen(stop_seen), .rx_char(rx_char),
        .ninth_mode(ninth_mode), .wake_sel(wake_sel), .idle_from_stop(idle_from_stop),
        .sleep_req(sleep_req), .asleep(asleep), .wake_pulse(wake_pulse),
        .idle_det(idle_det), .rx_accept(rx_accept)
    );

    // ninth, wake_sel, idle_from_stop, char, gap, exp idle, wake, accept, asleep
    typedef struct packed {
        logic       ninth;
        logic       ws;
        logic       ifs;
        logic [8:0] ch;
        logic [3:0] gap;
        logic       e_idle;
        logic       e_wake;
        logic       e_acc;
        logic       e_sleep;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        {1'b0,1'b0,1'b0,9'h000,4'd10,1'b1,1'b1,1'b0,1'b0},
        {1'b0,1'b0,1'b1,9'h000,4'd10,1'b1,1'b1,1'b0,1'b0},
        {1'b0,1'b0,1'b1,9'h000,4'd9, 1'b0,1'b0,1'b0,1'b1},
        {1'b0,1'b0,1'b0,9'h0FF,4'd1, 1'b1,1'b1,1'b0,1'b0},
        {1'b0,1'b0,1'b1,9'h0FF,4'd1, 1'b0,1'b0,1'b0,1'b1},
        {1'b0,1'b0,1'b0,9'h07F,4'd8, 1'b0,1'b0,1'b0,1'b1},
        {1'b0,1'b1,1'b1,9'h080,4'd2, 1'b0,1'b1,1'b1,1'b0},
        {1'b0,1'b1,1'b1,9'h07F,4'd10,1'b1,1'b0,1'b0,1'b1},
        {1'b1,1'b1,1'b1,9'h080,4'd2, 1'b0,1'b0,1'b0,1'b1},
        {1'b1,1'b1,1'b1,9'h100,4'd2, 1'b0,1'b1,1'b1,1'b0},
        {1'b1,1'b0,1'b1,9'h000,4'd10,1'b0,1'b0,1'b0,1'b1},
        {1'b1,1'b0,1'b1,9'h000,4'd11,1'b1,1'b1,1'b0,1'b0},
        {1'b1,1'b0,1'b0,9'h1FF,4'd1, 1'b1,1'b1,1'b0,1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; drives one cycle, returns at the next negedge
    // with the outputs registered from that cycle.
    task automatic step(input logic rx, input logic tk, input logic st,
                        input logic sp, input logic slp, input logic [8:0] ch);
        rx_line = rx; bit_tick = tk; start_seen = st; stop_seen = sp;
        sleep_req = slp; rx_char = ch;
        @(posedge clk);
        @(negedge clk);
        s_asleep = asleep; s_wake = wake_pulse; s_idle = idle_det; s_acc = rx_accept;
        c_idle += int'(idle_det); c_wake += int'(wake_pulse); c_acc += int'(rx_accept);
        bit_tick = 1'b0; start_seen = 1'b0; stop_seen = 1'b0; sleep_req = 1'b0;
        rx_line = 1'b1;
    endtask

    task automatic send_frame(input logic [8:0] ch);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
        for (int i = 0; i < (ninth_mode ? 9 : 8); i++)
            step(ch[i], 1'b1, 1'b0, 1'b0, 1'b0, '0);
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, ch);
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        c_idle = 0; c_wake = 0; c_acc = 0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 asleep", int'(asleep), 0);
        check("R1 wake_pulse", int'(wake_pulse), 0);
        check("R1 idle_det", int'(idle_det), 0);
        check("R1 rx_accept", int'(rx_accept), 0);
        // R1: no idle before a 0 has been seen
        idle_from_stop = 1'b1;
        ones(12);
        check("R1 idle without prior zero", c_idle, 0);

        // Vector table: sleep, one frame, then an idle gap.
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VEC[v];
            do_reset();
            ninth_mode = t.ninth; wake_sel = t.ws; idle_from_stop = t.ifs;
            step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0);
            c_idle = 0; c_wake = 0; c_acc = 0;
            send_frame(t.ch);
            ones(int'(t.gap));
            // Covers R3 R4 R5 R6 R7 R9 R10 R12 across the table.
            check($sformatf("vec %0d idle [R6 R7 R9 R10 R12]", v), c_idle, int'(t.e_idle));
            check($sformatf("vec %0d wake [R3 R4 R5 R12]", v), c_wake, int'(t.e_wake));
            check($sformatf("vec %0d accept [R2 R4 R5]", v), c_acc, int'(t.e_acc));
            check($sformatf("vec %0d asleep [R3 R4 R5]", v), int'(s_asleep), int'(t.e_sleep));
        end

        // R2: sleep request takes effect next cycle
        do_reset();
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0);
        check("R2 asleep after request", int'(s_asleep), 1);

        // R11: awake accept timing
        do_reset();
        wake_sel = 1'b0; ninth_mode = 1'b0; idle_from_stop = 1'b0;
        send_frame(9'h055);
        check("R11 accept on stop", int'(s_acc), 1);
        check("R11 single accept", c_acc, 1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        check("R11 accept one cycle", int'(s_acc), 0);

        // R8 and R6 boundary: idle once per run, rearmed by a zero
        do_reset();
        idle_from_stop = 1'b1; ninth_mode = 1'b0;
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        ones(9);
        check("R6 no idle at 9 ones", c_idle, 0);
        ones(1);
        check("R6 idle at 10th one", int'(s_idle), 1);
        ones(20);
        check("R8 only one idle per run", c_idle, 1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        ones(10);
        check("R8 rearmed after zero", c_idle, 2);

        // R7: a zero in the middle restarts the count
        do_reset();
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        ones(6);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        ones(9);
        check("R7 count restarted", c_idle, 0);
        ones(1);
        check("R7 idle after full run", c_idle, 1);

        // R3: wake, idle and asleep fall in the same cycle
        do_reset();
        wake_sel = 1'b0; idle_from_stop = 1'b1;
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0);
        ones(10);
        check("R3 wake with idle", int'(s_wake), 1);
        check("R3 idle same cycle", int'(s_idle), 1);
        check("R3 asleep cleared", int'(s_asleep), 0);
        ones(1);
        check("R3 wake one cycle", int'(s_wake), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule